// File: doc/BRIEF.md
# Qualified event counter

This block is a single programmable performance counter. Every clock cycle it takes a small event count, that is the number of occurrences of some monitored event in that cycle, along with the current privilege level of the code being run. A configuration word decides how that count reaches a wide accumulator. The count can be added as it is. It can be turned into a one-per-cycle flag by comparing it against a threshold, and that comparison can be inverted. It can be reduced to one count per rising edge of the qualified condition. It can be masked by privilege level.

Software reads the accumulator at any time and can overwrite it. When the accumulator wraps, a sticky overflow flag is set, and that flag drives the interrupt request until software clears it. Selecting which event to count and chaining counters together belong to the surrounding logic.

Configuration word layout (CFG_W = 5 + CNT_W bits): bit 0 enable, bit 1 edge mode, bit 2 invert, bit 3 kernel-level enable, bit 4 user-level enable, bits [5 +: CNT_W] threshold.

Top module: `qual_event_counter`

## Requirements
- R1: A synchronous reset clears the accumulator to 0 and clears the overflow flag, so `irq` is 0. It also sets the edge history register to 1.
- R2: With enable set, threshold 0 and edge mode off, each cycle adds the raw event count to the accumulator, and the invert bit has no effect.
- R3: With a nonzero threshold, invert clear and edge mode off, the accumulator gains exactly 1 in each cycle where the event count is at least the threshold, and gains 0 otherwise.
- R4: With a nonzero threshold and invert set, the accumulator gains exactly 1 in each cycle where the event count is below the threshold, and gains 0 otherwise.
- R5: In edge mode the qualified condition is (count ≥ threshold, or count < threshold when inverted) if the threshold is nonzero, and count ≠ 0 if the threshold is zero, in both cases gated by privilege. The accumulator gains 1 only in a cycle where this condition is true and was false in the previous enabled cycle.
- R6: While enable is clear the edge history is held at 1. A condition that is already true in the first enabled cycle after a disable or after reset therefore produces no count.
- R7: With only the kernel-level enable set, counting happens only while the privilege level is 0.
- R8: With only the user-level enable set, counting happens only while the privilege level is 1, 2 or 3.
- R9: With both privilege enables clear, counting happens at every privilege level, exactly as if both were set.
- R10: With enable clear and no write, the accumulator holds its value whatever the event count is.
- R11: A write loads `wr_data` into the accumulator at the next edge. It takes priority over any increment in the same cycle, works while counting is disabled, and the value reads back on `rd_data`.
- R12: The accumulator wraps modulo 2^ACC_W. A wrap sets the overflow flag, which drives `irq` and stays set until `ovf_clr`. A wrap in the same cycle as `ovf_clr` leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_count | input | CNT_W | Event occurrences in this cycle |
| priv_lvl | input | 2 | Privilege level of the code running now, 0 is most privileged |
| cfg | input | CFG_W | Configuration word, layout as given above |
| wr_en | input | 1 | Load the accumulator from `wr_data` |
| wr_data | input | ACC_W | Value to load |
| ovf_clr | input | 1 | Clear the overflow flag |
| rd_data | output | ACC_W | Current accumulator value (registered) |
| irq | output | 1 | Interrupt request, the sticky overflow flag (registered) |

## Verification
Every result has a latency of exactly one clock. Inputs applied in a cycle, including a condition rising in edge mode, show up in `rd_data` and `irq` right after the next rising edge. The bench changes inputs and samples outputs a short delay after each edge, so each check sees the effect of exactly the inputs held over the previous cycle. The edge cases need two cycles of context: a condition true, then false, then true again. The stimulus table is ordered so that each expected accumulator value follows from the rows above it.

// File: rtl/qec_pkg.sv
package qec_pkg;
  // Flag positions inside the configuration word
  localparam int B_EN   = 0;
  localparam int B_EDGE = 1;
  localparam int B_INV  = 2;
  localparam int B_KRN  = 3;
  localparam int B_USR  = 4;
  localparam int THR_LSB = 5;

  localparam logic [1:0] PRIV_KERNEL = 2'd0;
endpackage

// File: rtl/qec_qualify.sv
module qec_qualify
  import qec_pkg::*;
#(
  parameter int CNT_W = 4,
  localparam int CFG_W = THR_LSB + CNT_W
) (
  input  logic [CNT_W-1:0] evt_count,
  input  logic [1:0]       priv_lvl,
  input  logic [CFG_W-1:0] cfg,
  output logic             cond,
  output logic [CNT_W-1:0] amt
);
  logic             kern_en, user_en, both_off, priv_ok;
  logic [CNT_W-1:0] thr;
  logic             thr_on, ge, raw;

  always_comb begin
    kern_en  = cfg[B_KRN];
    user_en  = cfg[B_USR];
    both_off = !kern_en && !user_en;
    priv_ok  = (priv_lvl == PRIV_KERNEL) ? (kern_en || both_off)
                                         : (user_en || both_off);
    thr      = cfg[THR_LSB +: CNT_W];
    thr_on   = |thr;
    ge       = (evt_count >= thr);
    raw      = thr_on ? (cfg[B_INV] ? !ge : ge) : (|evt_count);
    cond     = raw && priv_ok;
    if (!priv_ok)
      amt = '0;
    else if (thr_on)
      amt = {{(CNT_W-1){1'b0}}, raw};
    else
      amt = evt_count;
  end
endmodule

// File: rtl/qec_edge.sv
module qec_edge (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic cond,
  output logic pulse
);
  logic hist_q;

  always_ff @(posedge clk) begin
    if (rst || !en)
      hist_q <= 1'b1;
    else
      hist_q <= cond;
  end

  assign pulse = en && cond && !hist_q;

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse); // R5
  AST_HIST_PRIMED: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |-> !pulse); // R6
endmodule

// File: rtl/qec_accum.sv
module qec_accum #(
  parameter int CNT_W = 4,
  parameter int ACC_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] inc,
  input  logic             wr_en,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             ovf_clr,
  output logic [ACC_W-1:0] acc,
  output logic             ovf
);
  localparam int PAD_W = ACC_W + 1 - CNT_W;

  logic [ACC_W:0] sum;
  logic           carry;

  always_comb begin
    sum   = {1'b0, acc} + {{PAD_W{1'b0}}, inc};
    carry = sum[ACC_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      ovf <= 1'b0;
    end else begin
      if (wr_en)
        acc <= wr_data;
      else if (en)
        acc <= sum[ACC_W-1:0];
      if (en && !wr_en && carry)
        ovf <= 1'b1;
      else if (ovf_clr)
        ovf <= 1'b0;
    end
  end

  AST_WR_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> acc == $past(wr_data)); // R11
  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr_en) |=> $stable(acc)); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf); // R12
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $past(en && !wr_en)); // R12
endmodule

// File: rtl/qual_event_counter.sv
module qual_event_counter
  import qec_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int ACC_W = 48,
  localparam int CFG_W = THR_LSB + CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] evt_count,
  input  logic [1:0]       priv_lvl,
  input  logic [CFG_W-1:0] cfg,
  input  logic             wr_en,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             ovf_clr,
  output logic [ACC_W-1:0] rd_data,
  output logic             irq
);
  logic             cond, pulse, en;
  logic [CNT_W-1:0] amt, inc;
  logic [ACC_W-1:0] acc;
  logic             ovf;

  assign en = cfg[B_EN];

  qec_qualify #(.CNT_W(CNT_W)) u_qual (
    .evt_count(evt_count),
    .priv_lvl (priv_lvl),
    .cfg      (cfg),
    .cond     (cond),
    .amt      (amt)
  );

  qec_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .cond (cond),
    .pulse(pulse)
  );

  assign inc = cfg[B_EDGE] ? {{(CNT_W-1){1'b0}}, pulse} : amt;

  qec_accum #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .inc    (inc),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .ovf_clr(ovf_clr),
    .acc    (acc),
    .ovf    (ovf)
  );

  assign rd_data = acc;
  assign irq     = ovf;

  AST_KERN_ONLY: assert property (@(posedge clk) disable iff (rst)
    (cfg[B_KRN] && !cfg[B_USR] && priv_lvl != PRIV_KERNEL && !wr_en)
      |=> $stable(rd_data)); // R7
  AST_USER_ONLY: assert property (@(posedge clk) disable iff (rst)
    (cfg[B_USR] && !cfg[B_KRN] && priv_lvl == PRIV_KERNEL && !wr_en)
      |=> $stable(rd_data)); // R8
endmodule

// File: tb/tb_qual_event_counter.sv
module tb_qual_event_counter;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 4;
  localparam int ACC_W = 48;
  localparam int CFG_W = 5 + CNT_W;
  localparam int MAX_CYC = 200000;
  localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};

  // {req 4b, cfg 9b, priv 2b, evt 4b, expected acc 16b}
  localparam int NV = 28;
  localparam logic [34:0] VEC [NV] = '{
    {4'd2, 9'h001, 2'd0, 4'd3, 16'd3},   // R2 raw add
    {4'd2, 9'h001, 2'd2, 4'd5, 16'd8},   // R2 / R9 any level
    {4'd2, 9'h005, 2'd1, 4'd2, 16'd10},  // R2 invert ignored
    {4'd3, 9'h041, 2'd0, 4'd3, 16'd11},  // R3 above threshold
    {4'd3, 9'h041, 2'd0, 4'd1, 16'd11},  // R3 below
    {4'd3, 9'h041, 2'd0, 4'd2, 16'd12},  // R3 equal
    {4'd4, 9'h045, 2'd0, 4'd1, 16'd13},  // R4 below counts
    {4'd4, 9'h045, 2'd0, 4'd2, 16'd13},  // R4 equal does not
    {4'd4, 9'h045, 2'd0, 4'd0, 16'd14},  // R4 zero counts
    {4'd7, 9'h009, 2'd0, 4'd4, 16'd18},  // R7 level 0
    {4'd7, 9'h009, 2'd3, 4'd4, 16'd18},  // R7 level 3 blocked
    {4'd8, 9'h011, 2'd0, 4'd4, 16'd18},  // R8 level 0 blocked
    {4'd8, 9'h011, 2'd1, 4'd2, 16'd20},  // R8 level 1
    {4'd9, 9'h019, 2'd3, 4'd1, 16'd21},  // R9 both set
    {4'd10, 9'h000, 2'd0, 4'd7, 16'd21}, // R10 frozen
    {4'd6, 9'h003, 2'd0, 4'd2, 16'd21},  // R6 true on enable
    {4'd5, 9'h003, 2'd0, 4'd0, 16'd21},  // R5 low
    {4'd5, 9'h003, 2'd0, 4'd5, 16'd22},  // R5 rise
    {4'd5, 9'h003, 2'd0, 4'd5, 16'd22},  // R5 held
    {4'd5, 9'h003, 2'd0, 4'd1, 16'd22},  // R5 held
    {4'd5, 9'h003, 2'd0, 4'd0, 16'd22},  // R5 low
    {4'd5, 9'h003, 2'd0, 4'd3, 16'd23},  // R5 rise
    {4'd5, 9'h063, 2'd0, 4'd3, 16'd23},  // R5 threshold, still true
    {4'd5, 9'h063, 2'd0, 4'd2, 16'd23},  // R5 falls
    {4'd5, 9'h063, 2'd0, 4'd4, 16'd24},  // R5 rises
    {4'd7, 9'h00B, 2'd1, 4'd1, 16'd24},  // R7 edge blocked by level
    {4'd7, 9'h00B, 2'd0, 4'd1, 16'd25},  // R7 edge at level 0
    {4'd2, 9'h001, 2'd0, 4'd0, 16'd25}   // R2 zero count
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] evt_count = '0;
  logic [1:0]       priv_lvl = '0;
  logic [CFG_W-1:0] cfg = '0;
  logic             wr_en = 1'b0;
  logic [ACC_W-1:0] wr_data = '0;
  logic             ovf_clr = 1'b0;
  logic [ACC_W-1:0] rd_data;
  logic             irq;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qual_event_counter #(.CNT_W(CNT_W), .ACC_W(ACC_W)) dut (
    .clk(clk), .rst(rst), .evt_count(evt_count), .priv_lvl(priv_lvl),
    .cfg(cfg), .wr_en(wr_en), .wr_data(wr_data), .ovf_clr(ovf_clr),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [ACC_W-1:0] act,
                     input logic [ACC_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [CFG_W-1:0] c, input logic [1:0] p,
                       input logic [CNT_W-1:0] e);
    cfg = c; priv_lvl = p; evt_count = e;
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    step(); step();
    rst = 1'b0;
    chk("R1 acc", rd_data, '0);
    chk("R1 irq", {{(ACC_W-1){1'b0}}, irq}, '0);

    // R6: condition already true right after reset is no edge
    drive(9'h003, 2'd0, 4'd1); step();
    chk("R6", rd_data, '0);
    drive(9'h003, 2'd0, 4'd0); step();
    drive(9'h003, 2'd0, 4'd1); step();
    chk("R5", rd_data, 48'd1);

    // clear through a write while disabled (R11)
    drive(9'h000, 2'd0, 4'd0);
    wr_en = 1'b1; wr_data = '0; step();
    wr_en = 1'b0;
    chk("R11 disabled write", rd_data, '0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][30:22], VEC[i][21:20], VEC[i][19:16]);
      step();
      total++;
      if (rd_data !== {32'd0, VEC[i][15:0]}) begin
        bad++;
        $display("FAIL R%0d row %0d actual=%0d expected=%0d",
                 VEC[i][34:31], i, rd_data, VEC[i][15:0]);
      end
    end

    // R11: write beats increment, then counting resumes from it
    drive(9'h001, 2'd0, 4'd5);
    wr_en = 1'b1; wr_data = 48'h0123_4567_89AB; step();
    wr_en = 1'b0;
    chk("R11 priority", rd_data, 48'h0123_4567_89AB);
    step();
    chk("R11 resume", rd_data, 48'h0123_4567_89B0);

    // R12: write near max wins with no overflow, then wrap
    drive(9'h001, 2'd0, 4'd3);
    wr_en = 1'b1; wr_data = ACC_MAX - 48'd1; step();
    wr_en = 1'b0;
    chk("R12 no ovf on write", {{(ACC_W-1){1'b0}}, irq}, '0);
    step();
    chk("R12 wrap value", rd_data, 48'd1);
    chk("R12 irq set", {{(ACC_W-1){1'b0}}, irq}, 48'd1);
    drive(9'h000, 2'd0, 4'd0); step(); step();
    chk("R12 sticky", {{(ACC_W-1){1'b0}}, irq}, 48'd1);
    ovf_clr = 1'b1; step();
    ovf_clr = 1'b0;
    chk("R12 cleared", {{(ACC_W-1){1'b0}}, irq}, '0);
    wr_en = 1'b1; wr_data = ACC_MAX; step();
    wr_en = 1'b0;
    drive(9'h001, 2'd0, 4'd1);
    ovf_clr = 1'b1; step();
    ovf_clr = 1'b0;
    drive(9'h000, 2'd0, 4'd0);
    chk("R12 exact wrap", rd_data, '0);
    chk("R12 set beats clear", {{(ACC_W-1){1'b0}}, irq}, 48'd1);

    // R1: reset in mid-run
    wr_en = 1'b1; wr_data = 48'd77; step();
    wr_en = 1'b0;
    rst = 1'b1; step();
    rst = 1'b0;
    chk("R1 acc after run", rd_data, '0);
    chk("R1 irq after run", {{(ACC_W-1){1'b0}}, irq}, '0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule